// File: doc/BRIEF.md
# I2C Write-Only Command Target

This block is an I2C target that receives write transactions addressed to it and turns them into register write strobes for a small register file. It samples the bus lines with a system clock that is much faster than SCL. Both lines pass through two-flop synchronisers, and the block finds START, STOP and the SCL edges from the synchronised samples. It acknowledges a byte by asserting an open-drain pull-down enable on SDA.

A transaction has three parts: the device address byte, a command byte, and any number of data bytes. The command byte does two jobs. Its top bit asks for a new conversion, and the block issues that request as a one-cycle pulse when it starts the acknowledge of the command byte. Its low seven bits set the register pointer. Each data byte after that is written at the pointer, and the pointer then steps forward by one. Read requests and foreign addresses are not acknowledged, and the block stays silent until the next START or STOP.

Top module: `i2c_cmd_target`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. A later START (SDA falling while SCL is high) begins a fresh transaction that is handled normally.
- R2: When the first byte after START holds the configured 7-bit device address in bits [7:1] and 0 in bit 0, the block asserts `sda_oe` during the ninth SCL pulse of that byte.
- R3: If the address in the first byte differs from the device address, no ACK is given for that byte or any later byte, and no write strobe or conversion pulse is produced until the next START or STOP.
- R4: A first byte that matches the device address but has bit 0 set (read) is not acknowledged and is otherwise treated as in R3.
- R5: The second byte is acknowledged. Its bits [6:0] load the register pointer, and it produces no write strobe.
- R6: If bit 7 of the second byte is 1, `conv_start` pulses high for exactly one system clock, in the cycle where the block starts driving that byte's ACK. If bit 7 is 0, there is no pulse.
- R7: Every data byte after the second is acknowledged. It produces a single-cycle `wr_stb` carrying the current pointer on `wr_addr` and the byte (first bit received as MSB) on `wr_data`. The strobe is issued once the eighth bit has been sampled.
- R8: After each data byte the pointer advances by one, and it wraps from 0x7F to 0x00.
- R9: A STOP or repeated START in the middle of a byte discards the partial byte, so no write takes place. A repeated START releases SDA and begins a new address phase.
- R10: While reset is held, `sda_oe`, `wr_stb` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | When high, the SDA line is pulled low (ACK) |
| wr_stb | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 7 | Register address for the write |
| wr_data | output | 8 | Data byte for the write |
| conv_start | output | 1 | Single-cycle conversion request pulse |

## Verification
A wrong phase or byte state shows up on SDA within one byte. The bus controller sees a missing or extra ACK at the ninth clock, or sees SDA held low at a point where it should be released. A wrong pointer shows up on the next data byte as a strobe that carries the wrong address. A wrong bit count shows up as a `wr_data` value shifted by one position, or as a strobe that never comes. A trigger flag that is latched incorrectly appears at the command byte's ACK as a missing or extra `conv_start` pulse.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_DEVADDR,
        RX_CMD,
        RX_DATA,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic [6:0] dev;
        logic       rnw;
    } addr_byte_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_accept(input logic [7:0] b, input logic [6:0] dev);
        addr_byte_t a;
        a = addr_byte_t'(b);
        return (a.dev == dev) && !a.rnw;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_wr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= ld_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h35,
    parameter int         DW       = 8,
    localparam int        AW       = DW - 1,
    localparam int        CW       = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [AW-1:0] ptr,
    output logic          ptr_load,
    output logic [AW-1:0] ptr_ld_val,
    output logic          ptr_inc,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          conv_start,
    output rx_state_e     state
);
    logic [CW-1:0] bit_cnt;
    logic [DW-2:0] shreg;
    logic          ack_on;
    logic          trig_q;
    logic          match_q;
    logic          receiving;
    logic          byte_done;
    logic          last_bit;
    logic [DW-1:0] full_byte;

    always_comb begin
        receiving  = (state == RX_DEVADDR) || (state == RX_CMD) || (state == RX_DATA);
        byte_done  = (bit_cnt == CW'(DW));
        full_byte  = {shreg, evt.sda};
        last_bit   = receiving && !ack_on && evt.scl_rise && (bit_cnt == CW'(DW - 1));
        ptr_load   = last_bit && (state == RX_CMD);
        ptr_ld_val = full_byte[AW-1:0];
        ptr_inc    = last_bit && (state == RX_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            ack_on     <= 1'b0;
            trig_q     <= 1'b0;
            match_q    <= 1'b0;
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            conv_start <= 1'b0;
        end else begin
            wr_stb     <= 1'b0;
            conv_start <= 1'b0;
            if (evt.start) begin
                state   <= RX_DEVADDR;
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state   <= RX_IDLE;
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (receiving) begin
                if (evt.scl_rise && !byte_done && !ack_on) begin
                    shreg   <= full_byte[DW-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        case (state)
                            RX_DEVADDR: match_q <= addr_accept(full_byte[7:0], DEV_ADDR);
                            RX_CMD:     trig_q  <= full_byte[DW-1];
                            RX_DATA: begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= full_byte;
                            end
                            default: ;
                        endcase
                    end
                end else if (evt.scl_fall && byte_done && !ack_on) begin
                    if (state == RX_DEVADDR && !match_q) begin
                        state   <= RX_SKIP;
                        bit_cnt <= '0;
                    end else begin
                        ack_on <= 1'b1;
                        sda_oe <= 1'b1;
                        if (state == RX_CMD && trig_q) conv_start <= 1'b1;
                    end
                end else if (evt.scl_fall && ack_on) begin
                    ack_on  <= 1'b0;
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                    if (state == RX_DEVADDR)  state <= RX_CMD;
                    else if (state == RX_CMD) state <= RX_DATA;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h35,
    parameter int         SYNC_STAGES = 2,
    parameter int         DATA_W      = 8,
    localparam int        REG_AW      = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              conv_start
);
    logic [1:0]        lines_s;
    bus_evt_t          evt;
    logic              ptr_load;
    logic              ptr_inc;
    logic [REG_AW-1:0] ptr_ld_val;
    logic [REG_AW-1:0] ptr;
    rx_state_e         state;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    i2c_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt   (evt)
    );

    i2c_reg_ptr #(.AW(REG_AW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .load   (ptr_load),
        .ld_val (ptr_ld_val),
        .inc    (ptr_inc),
        .ptr    (ptr)
    );

    i2c_wr_ctrl #(.DEV_ADDR(DEV_ADDR), .DW(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .ptr        (ptr),
        .ptr_load   (ptr_load),
        .ptr_ld_val (ptr_ld_val),
        .ptr_inc    (ptr_inc),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .conv_start (conv_start),
        .state      (state)
    );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk
    import i2c_wr_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sda_oe,
    input logic      wr_stb,
    input logic      conv_start,
    input logic      start_evt,
    input logic      stop_evt,
    input rx_state_e state
);
    p_stb_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_stb_not_acking_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !sda_oe);

    p_conv_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_conv_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> sda_oe);

    p_skip_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SKIP) |-> (!sda_oe && !wr_stb && !conv_start));

    p_restart_release_r9: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (!sda_oe && state == RX_DEVADDR));

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (!sda_oe && state == RX_IDLE));
endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_oe     (sda_oe),
    .wr_stb     (wr_stb),
    .conv_start (conv_start),
    .start_evt  (evt.start),
    .stop_evt   (evt.stop),
    .state      (state)
);

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h35;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       wr_stb;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       conv_start;

    int n_checks = 0;
    int n_fail   = 0;
    int conv_seen = 0;

    typedef struct {
        logic [6:0] a;
        logic [7:0] d;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_cmd_target #(.DEV_ADDR(DEV)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .conv_start (conv_start)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: R7 / R8 write strobes
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected write strobe addr", int'(wr_addr), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(wr_addr == e.a, "R8", "write address", int'(wr_addr), int'(e.a));
                chk(wr_data == e.d, "R7", "write data", int'(wr_data), int'(e.d));
            end
        end
        if (!rst && conv_start) conv_seen++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [6:0] a, input logic [7:0] d);
        exp_t e;
        e.a = a;
        e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_oe;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        int   cbase;

        tick(5);
        chk(sda_oe == 1'b0, "R10", "sda_oe in reset", int'(sda_oe), 0);
        chk(wr_stb == 1'b0, "R10", "wr_stb in reset", int'(wr_stb), 0);
        chk(conv_start == 1'b0, "R10", "conv_start in reset", int'(conv_start), 0);
        rst = 1'b0;
        tick(10);

        // T1: trigger set, pointer 0x05, three data bytes
        cbase = conv_seen;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack == 1'b1, "R2", "address ack", int'(ack), 1);
        send_byte(8'h85, ack);       chk(ack == 1'b1, "R5", "command ack", int'(ack), 1);
        chk(conv_seen == cbase + 1, "R6", "conv pulses with trigger", conv_seen - cbase, 1);
        push_exp(7'h05, 8'hA1); send_byte(8'hA1, ack); chk(ack == 1'b1, "R7", "data ack", int'(ack), 1);
        push_exp(7'h06, 8'hB2); send_byte(8'hB2, ack); chk(ack == 1'b1, "R7", "data ack", int'(ack), 1);
        push_exp(7'h07, 8'hC3); send_byte(8'hC3, ack);
        bus_stop();
        chk(exp_q.size() == 0, "R8", "pending writes after T1", exp_q.size(), 0);

        // T2: no trigger, pointer wraps past 0x7F
        cbase = conv_seen;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h7E, ack);
        chk(conv_seen == cbase, "R6", "conv pulses without trigger", conv_seen - cbase, 0);
        push_exp(7'h7E, 8'h11); send_byte(8'h11, ack);
        push_exp(7'h7F, 8'h22); send_byte(8'h22, ack);
        push_exp(7'h00, 8'h33); send_byte(8'h33, ack);
        bus_stop();
        chk(exp_q.size() == 0, "R8", "pending writes after wrap", exp_q.size(), 0);

        // T3: foreign address
        cbase = conv_seen;
        bus_start();
        send_byte({DEV + 7'd1, 1'b0}, ack); chk(ack == 1'b0, "R3", "foreign address ack", int'(ack), 0);
        send_byte(8'h81, ack); chk(ack == 1'b0, "R3", "byte after mismatch ack", int'(ack), 0);
        send_byte(8'h44, ack); chk(ack == 1'b0, "R3", "data after mismatch ack", int'(ack), 0);
        chk(conv_seen == cbase, "R3", "conv after mismatch", conv_seen - cbase, 0);
        bus_stop();

        // T4: read request
        cbase = conv_seen;
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack == 1'b0, "R4", "read request ack", int'(ack), 0);
        send_byte(8'h80, ack);       chk(ack == 1'b0, "R4", "byte after read ack", int'(ack), 0);
        chk(conv_seen == cbase, "R4", "conv after read", conv_seen - cbase, 0);
        bus_stop();

        // T5: partial byte then STOP
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        push_exp(7'h10, 8'h55); send_byte(8'h55, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        tick(20);
        chk(exp_q.size() == 0, "R9", "pending writes after partial byte", exp_q.size(), 0);
        chk(sda_oe == 1'b0, "R9", "sda released after stop", int'(sda_oe), 0);

        // T6: repeated START in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h20, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        chk(sda_oe == 1'b0, "R9", "sda released after repeated start", int'(sda_oe), 0);
        send_byte({DEV, 1'b0}, ack); chk(ack == 1'b1, "R9", "address ack after repeated start", int'(ack), 1);
        send_byte(8'h30, ack);
        push_exp(7'h30, 8'h77); send_byte(8'h77, ack);
        bus_stop();

        // T7: STOP right after address, then a fresh transaction
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        bus_stop();
        chk(sda_oe == 1'b0, "R1", "idle after stop", int'(sda_oe), 0);
        cbase = conv_seen;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack == 1'b1, "R1", "address ack on new transaction", int'(ack), 1);
        send_byte(8'h85, ack);
        chk(conv_seen == cbase + 1, "R6", "conv pulses on new transaction", conv_seen - cbase, 1);
        push_exp(7'h05, 8'h99); send_byte(8'h99, ack);
        bus_stop();
        tick(20);

        chk(exp_q.size() == 0, "R7", "writes still expected at end", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule